// File: doc/BRIEF.md
# Reordering DRAM Transaction Scheduler

This block sits between the request side of a memory system and an abstract DRAM command port. It accepts cache-line read and write requests, each already split into bank, row and column plus a completion tag, and keeps them in a small look-ahead queue. Every cycle it picks at most one command from the queue: a column read or write for a request whose row is open and ready, an activate for a request whose bank is idle and clear of its timers, or a precharge that closes a row that no queued request still wants.

Per-bank timers hold the activate-to-column delay, the same-bank activate-to-activate delay and the precharge-to-activate delay. Requests are not served strictly in arrival order. A request that has just entered the queue can activate its bank at once, while older requests finish, so its activate delay overlaps with useful transfers. A request whose bank must wait out the activate-to-activate delay does not stall requests to other banks. Among requests that are ready, the oldest goes first. Two requests to the same line therefore complete in arrival order. A completion pulse carries the request's tag in the cycle its column command is issued.

Top module: `dram_reorder_sched`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low exactly when `DEPTH` requests are queued and not yet completed.
- R2: A column command to a bank issues no sooner than `T_RCD` cycles after that bank's activate. When nothing else competes, it issues exactly `T_RCD` cycles after the activate.
- R3: Two activates to the same bank are at least `T_RC` cycles apart. A request held only by this limit activates in the first cycle the limit allows.
- R4: An activate goes only to a closed bank, at least `T_RP` cycles after that bank's precharge. A precharge goes only to an open bank. A request to a different row of an open bank waits for a precharge: with clear timers it completes `1 + T_RP + T_RCD` cycles after acceptance.
- R5: A request whose row is already open in its bank is served with no new activate. An idle hit completes one cycle after acceptance. The column command always carries the open row of its bank.
- R6: A request waiting on the activate-to-activate limit of its bank does not hold back younger requests to other banks.
- R7: Among requests that are eligible for the same kind of command, the oldest is chosen. Two requests to the same bank, row and column complete in arrival order.
- R8: At most one command is issued per cycle. A column command wins over an activate, and an activate wins over a precharge.
- R9: `done_valid` pulses with the request's `done_tag` in the cycle of its column command and at no other time. Every accepted tag completes exactly once.
- R10: A request to an idle closed bank with clear timers gets its activate in the cycle after acceptance, even while older requests are still waiting.
- R11: After reset the queue is empty, every bank is closed, `req_ready` is high, and no command or completion is issued.
- R12: `cmd_kind` encodes 0 as precharge, 1 as activate, 2 as column read and 3 as column write. A request with `req_write` high completes with kind 3, otherwise with kind 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column (cache-line slot) |
| req_tag | input | TAG_W | Completion tag |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for activate and column commands |
| cmd_col | output | COL_W | Column for column commands |
| done_valid | output | 1 | A request completes this cycle |
| done_tag | output | TAG_W | Tag of the completing request |

## Verification
On every cycle, the assertions check that no activate reaches a bank that is open or still inside its activate-to-activate or precharge-to-activate window. They also check that no column command reaches a bank before its activate delay has run out, that no precharge targets a closed bank, and that the queue never takes a request while full or retires an empty slot. The scheduling choices themselves can only be shown by the bench's scenarios, with issue cycles worked out arithmetically from the three delays: which request goes first, the overlap of one bank's activate with another bank's transfers, column-over-activate priority, the bypass of a request blocked by its bank's activate-to-activate limit, and the fill-to-full behaviour of the queue.

// File: rtl/drs_pkg.sv
// Shared types of the reordering DRAM scheduler.
// Assumes: command kinds are seen by neighbours as a 2-bit code.
package drs_pkg;

    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } drs_cmd_e;

endpackage

// File: rtl/drs_bank_timer.sv
// Tracks one DRAM bank: whether a row is open, which row, and the three
// countdowns (activate-to-column, activate-to-activate, precharge-to-activate).
// Assumes: the scheduler raises at most one of act_i / pre_i / col_i per cycle
// and only when the matching *_ok output allows it; all delays are >= 1.
module drs_bank_timer #(
    parameter int ROW_W = 8,
    parameter int T_RCD = 4,
    parameter int T_RC  = 12,
    parameter int T_RP  = 3,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             col_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             is_open_o,
    output logic [ROW_W-1:0] open_row_o,
    output logic             col_ok_o,
    output logic             act_ok_o
);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] rcd_cnt;
    logic [CNT_W-1:0] rc_cnt;
    logic [CNT_W-1:0] rp_cnt;

    // Open/closed state and the row held in the sense amplifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (act_i) begin
            open_q <= 1'b1;
            row_q  <= row_i;
        end else if (pre_i) begin
            open_q <= 1'b0;
        end
    end

    // Countdowns: reload on the starting command, then run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            rc_cnt  <= '0;
            rp_cnt  <= '0;
        end else begin
            if (act_i)              rcd_cnt <= CNT_W'(T_RCD - 1);
            else if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - CNT_W'(1);
            if (act_i)              rc_cnt  <= CNT_W'(T_RC - 1);
            else if (rc_cnt != '0)  rc_cnt  <= rc_cnt - CNT_W'(1);
            if (pre_i)              rp_cnt  <= CNT_W'(T_RP - 1);
            else if (rp_cnt != '0)  rp_cnt  <= rp_cnt - CNT_W'(1);
        end
    end

    assign is_open_o  = open_q;
    assign open_row_o = row_q;
    assign col_ok_o   = open_q && (rcd_cnt == '0);
    assign act_ok_o   = !open_q && (rc_cnt == '0) && (rp_cnt == '0);

    assert_act_after_trc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (rc_cnt == '0));
    assert_act_closed_trp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (!open_q && rp_cnt == '0));
    assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> open_q);
    assert_col_after_trcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col_i |-> (open_q && rcd_cnt == '0));

endmodule

// File: rtl/drs_queue.sv
// Age-ordered request queue. Slot 0 always holds the oldest request; a
// retired slot is closed up by shifting younger slots down, and a new
// request is written just behind the youngest survivor.
// Assumes: push only when not full; pop_idx names a live slot.
module drs_queue #(
    parameter int DEPTH  = 6,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         push_wr,
    input  logic [BANK_W-1:0]            push_bank,
    input  logic [ROW_W-1:0]             push_row,
    input  logic [COL_W-1:0]             push_col,
    input  logic [TAG_W-1:0]             push_tag,
    input  logic                         pop,
    input  logic [IDX_W-1:0]             pop_idx,
    output logic [DEPTH-1:0]             q_vld,
    output logic [DEPTH-1:0]             q_wr,
    output logic [DEPTH-1:0][BANK_W-1:0] q_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]  q_row,
    output logic [DEPTH-1:0][COL_W-1:0]  q_col,
    output logic [DEPTH-1:0][TAG_W-1:0]  q_tag,
    output logic                         full
);

    logic [CNT_W-1:0]             count;
    logic [CNT_W-1:0]             cnt_mid;
    logic [DEPTH-1:0]             n_wr;
    logic [DEPTH-1:0][BANK_W-1:0] n_bank;
    logic [DEPTH-1:0][ROW_W-1:0]  n_row;
    logic [DEPTH-1:0][COL_W-1:0]  n_col;
    logic [DEPTH-1:0][TAG_W-1:0]  n_tag;

    // Next contents: close the gap left by a pop, then append a push.
    always_comb begin
        n_wr   = q_wr;
        n_bank = q_bank;
        n_row  = q_row;
        n_col  = q_col;
        n_tag  = q_tag;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop && (IDX_W'(i) >= pop_idx)) begin
                n_wr[i]   = q_wr[i+1];
                n_bank[i] = q_bank[i+1];
                n_row[i]  = q_row[i+1];
                n_col[i]  = q_col[i+1];
                n_tag[i]  = q_tag[i+1];
            end
        end
        cnt_mid = pop ? (count - CNT_W'(1)) : count;
        for (int i = 0; i < DEPTH; i++) begin
            if (push && (CNT_W'(i) == cnt_mid)) begin
                n_wr[i]   = push_wr;
                n_bank[i] = push_bank;
                n_row[i]  = push_row;
                n_col[i]  = push_col;
                n_tag[i]  = push_tag;
            end
        end
    end

    // Slot storage and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            q_wr   <= '0;
            q_bank <= '0;
            q_row  <= '0;
            q_col  <= '0;
            q_tag  <= '0;
        end else begin
            count  <= cnt_mid + (push ? CNT_W'(1) : CNT_W'(0));
            q_wr   <= n_wr;
            q_bank <= n_bank;
            q_row  <= n_row;
            q_col  <= n_col;
            q_tag  <= n_tag;
        end
    end

    // Live-slot mask derived from the occupancy count.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) q_vld[i] = (CNT_W'(i) < count);
    end

    assign full = (count == CNT_W'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));
    assert_pop_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (CNT_W'(pop_idx) < count));

endmodule

// File: rtl/drs_picker.sv
// Chooses the single command for this cycle from the queue and bank state.
// Column for the oldest request hitting a ready open row, else activate for
// the oldest request whose bank is closed and clear, else precharge of the
// bank of the oldest request that misses an open row no one else still hits.
// Assumes: slot 0 is the oldest; NUM_BANKS is a power of two.
module drs_picker #(
    parameter int DEPTH     = 6,
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 8,
    parameter int IDX_W     = 3
) (
    input  logic [DEPTH-1:0]                q_vld,
    input  logic [DEPTH-1:0][BANK_W-1:0]    q_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]     q_row,
    input  logic [NUM_BANKS-1:0]            bk_open,
    input  logic [NUM_BANKS-1:0]            bk_col_ok,
    input  logic [NUM_BANKS-1:0]            bk_act_ok,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] bk_row,
    output logic                            sel_valid,
    output drs_pkg::drs_cmd_e               sel_kind,
    output logic [IDX_W-1:0]                sel_idx,
    output logic                            sel_pop
);
    import drs_pkg::*;

    logic [NUM_BANKS-1:0] has_hit;
    logic [NUM_BANKS-1:0] has_miss;
    logic [NUM_BANKS-1:0] need_pre;
    logic [DEPTH-1:0]     col_elig;
    logic [DEPTH-1:0]     act_elig;
    logic [DEPTH-1:0]     pre_elig;
    logic                 col_any, act_any, pre_any;
    logic [IDX_W-1:0]     col_idx, act_idx, pre_idx;

    // Per bank: does any queued request hit or miss the open row.
    always_comb begin
        has_hit  = '0;
        has_miss = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_vld[i]) begin
                if (q_row[i] == bk_row[q_bank[i]]) has_hit[q_bank[i]]  = 1'b1;
                else                               has_miss[q_bank[i]] = 1'b1;
            end
        end
        need_pre = bk_open & bk_col_ok & has_miss & ~has_hit;
    end

    // Per entry: which command kinds it could take right now.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            col_elig[i] = q_vld[i] && bk_col_ok[q_bank[i]] && (q_row[i] == bk_row[q_bank[i]]);
            act_elig[i] = q_vld[i] && bk_act_ok[q_bank[i]];
            pre_elig[i] = q_vld[i] && need_pre[q_bank[i]];
        end
    end

    // Oldest eligible entry of each kind (lowest slot wins).
    always_comb begin
        col_any = 1'b0; act_any = 1'b0; pre_any = 1'b0;
        col_idx = '0;   act_idx = '0;   pre_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (col_elig[i]) begin col_any = 1'b1; col_idx = IDX_W'(i); end
            if (act_elig[i]) begin act_any = 1'b1; act_idx = IDX_W'(i); end
            if (pre_elig[i]) begin pre_any = 1'b1; pre_idx = IDX_W'(i); end
        end
    end

    // Fixed priority among the three kinds.
    always_comb begin
        sel_valid = col_any || act_any || pre_any;
        sel_pop   = col_any;
        if (col_any) begin
            sel_idx  = col_idx;
            sel_kind = CMD_RD;
        end else if (act_any) begin
            sel_idx  = act_idx;
            sel_kind = CMD_ACT;
        end else begin
            sel_idx  = pre_idx;
            sel_kind = CMD_PRE;
        end
    end

endmodule

// File: rtl/dram_reorder_sched.sv
// Top of the reordering DRAM scheduler: request queue, command picker and
// one timer per bank. Issues one abstract command per cycle and reports
// completion with the request's tag on the column command.
// Assumes: NUM_BANKS is a power of two; all delays fit TIMER_MAX.
module dram_reorder_sched #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int COL_W     = 6,
    parameter int TAG_W     = 4,
    parameter int DEPTH     = 6,
    parameter int T_RCD     = 4,
    parameter int T_RC      = 12,
    parameter int T_RP      = 3,
    parameter int TIMER_MAX = 72,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int TMR_W    = $clog2(TIMER_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag
);
    import drs_pkg::*;

    logic [DEPTH-1:0]                q_vld, q_wr;
    logic [DEPTH-1:0][BANK_W-1:0]    q_bank;
    logic [DEPTH-1:0][ROW_W-1:0]     q_row;
    logic [DEPTH-1:0][COL_W-1:0]     q_col;
    logic [DEPTH-1:0][TAG_W-1:0]     q_tag;
    logic                            q_full;
    logic [NUM_BANKS-1:0]            bk_open, bk_col_ok, bk_act_ok;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bk_row;
    logic                            sel_valid, sel_pop;
    drs_cmd_e                        sel_kind;
    logic [IDX_W-1:0]                sel_idx;
    logic                            push;
    drs_cmd_e                        out_kind;

    assign push      = req_valid && !q_full;
    assign req_ready = !q_full;

    drs_queue #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .TAG_W(TAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_wr(req_write), .push_bank(req_bank),
        .push_row(req_row), .push_col(req_col), .push_tag(req_tag),
        .pop(sel_pop), .pop_idx(sel_idx),
        .q_vld(q_vld), .q_wr(q_wr), .q_bank(q_bank), .q_row(q_row),
        .q_col(q_col), .q_tag(q_tag), .full(q_full)
    );

    drs_picker #(
        .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .IDX_W(IDX_W)
    ) u_picker (
        .q_vld(q_vld), .q_bank(q_bank), .q_row(q_row),
        .bk_open(bk_open), .bk_col_ok(bk_col_ok), .bk_act_ok(bk_act_ok),
        .bk_row(bk_row),
        .sel_valid(sel_valid), .sel_kind(sel_kind), .sel_idx(sel_idx),
        .sel_pop(sel_pop)
    );

    // Column direction comes from the chosen request's write flag.
    always_comb begin
        if (sel_kind == CMD_RD) out_kind = q_wr[sel_idx] ? CMD_WR : CMD_RD;
        else                    out_kind = sel_kind;
    end

    assign cmd_valid  = sel_valid;
    assign cmd_kind   = out_kind;
    assign cmd_bank   = q_bank[sel_idx];
    assign cmd_row    = q_row[sel_idx];
    assign cmd_col    = q_col[sel_idx];
    assign done_valid = sel_valid && sel_pop;
    assign done_tag   = q_tag[sel_idx];

    // One timer per bank, driven by the decoded command strobes.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit_bank;
        assign hit_bank = sel_valid && (q_bank[sel_idx] == BANK_W'(g));

        drs_bank_timer #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP), .CNT_W(TMR_W)
        ) u_timer (
            .clk(clk), .rst_n(rst_n),
            .act_i(hit_bank && sel_kind == CMD_ACT),
            .pre_i(hit_bank && sel_kind == CMD_PRE),
            .col_i(hit_bank && sel_pop),
            .row_i(q_row[sel_idx]),
            .is_open_o(bk_open[g]),
            .open_row_o(bk_row[g]),
            .col_ok_o(bk_col_ok[g]),
            .act_ok_o(bk_act_ok[g])
        );
    end

    assert_done_on_column_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (cmd_valid && cmd_kind[1]));

endmodule

// File: tb/dram_reorder_sched_test.sv
module dram_reorder_sched_test;
    localparam int T_RCD = 4;
    localparam int T_RC  = 12;
    localparam int T_RP  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic [5:0] req_col = '0;
    logic [3:0] req_tag = '0;
    logic       req_ready, cmd_valid, done_valid;
    logic [1:0] cmd_kind, cmd_bank;
    logic [7:0] cmd_row;
    logic [5:0] cmd_col;
    logic [3:0] done_tag;

    dram_reorder_sched uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_tag(req_tag), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .done_valid(done_valid), .done_tag(done_tag)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  checks = 0, fails = 0;
    int  last_act[4], last_pre[4], brow[4];
    bit  bopen[4];
    bit  outst[16];
    int  done_cyc[16], done_kind[16];
    int  act_count = 0, accepted = 0, completed = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    initial begin
        for (int b = 0; b < 4; b++) begin
            last_act[b] = -1000; last_pre[b] = -1000; bopen[b] = 0; brow[b] = 0;
        end
    end

    // Command monitor: every issued command against per-bank limits.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_valid && !(cmd_valid && cmd_kind[1]))
                chk(0, "R9 completion without column", 1, 0);
            if (cmd_valid) begin
                automatic int b = int'(cmd_bank);
                case (cmd_kind)
                    2'd0: begin
                        chk(bopen[b], "R4 precharge of closed bank", 0, 1);
                        bopen[b] = 0; last_pre[b] = cyc;
                    end
                    2'd1: begin
                        chk(!bopen[b], "R4 activate on open bank", 1, 0);
                        chk(cyc - last_act[b] >= T_RC, "R3 activate spacing", cyc - last_act[b], T_RC);
                        chk(cyc - last_pre[b] >= T_RP, "R4 precharge-to-activate", cyc - last_pre[b], T_RP);
                        bopen[b] = 1; brow[b] = int'(cmd_row); last_act[b] = cyc; act_count++;
                    end
                    default: begin
                        chk(bopen[b] && brow[b] == int'(cmd_row), "R5 column row", int'(cmd_row), brow[b]);
                        chk(cyc - last_act[b] >= T_RCD, "R2 activate-to-column", cyc - last_act[b], T_RCD);
                        chk(done_valid && outst[done_tag], "R9 tag completes once", int'(done_valid), 1);
                        outst[done_tag] = 0;
                        done_cyc[done_tag] = cyc;
                        done_kind[done_tag] = int'(cmd_kind);
                        completed++;
                    end
                endcase
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic push(input bit wr, input int bank, input int row, input int col,
                        input int tag, output int acc);
        req_valid = 1; req_write = wr; req_bank = 2'(bank); req_row = 8'(row);
        req_col = 6'(col); req_tag = 4'(tag);
        while (!req_ready) begin @(negedge clk); #1; end
        acc = cyc; outst[tag] = 1; accepted++;
        @(negedge clk); #1;
        req_valid = 0;
    endtask

    task automatic drain();
        int n = 0;
        while (n < 400) begin
            automatic bit busy = 0;
            for (int t = 0; t < 16; t++) if (outst[t]) busy = 1;
            if (!busy) break;
            idle(1); n++;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        int c0, c1, c2, c3, c4, a, acts0;
        repeat (3) @(negedge clk);
        #1;
        chk(cmd_valid == 0, "R11 no command after reset", int'(cmd_valid), 0);
        chk(done_valid == 0, "R11 no completion after reset", int'(done_valid), 0);
        chk(req_ready == 1, "R11 ready after reset", int'(req_ready), 1);
        rst_n = 1;
        idle(2);
        chk(cmd_valid == 0, "R11 idle when empty", int'(cmd_valid), 0);

        // S1: one activate serves three hits; column beats a new activate.
        acts0 = act_count;
        push(0, 0, 5, 0, 0, c0);
        push(0, 0, 5, 1, 1, a);
        push(0, 0, 5, 2, 2, a);
        idle(1);
        push(0, 1, 2, 3, 3, a);
        drain();
        chk(last_act[0] == c0 + 1, "R10 activate next cycle", last_act[0], c0 + 1);
        chk(done_cyc[0] == c0 + 1 + T_RCD, "R2 exact tRCD", done_cyc[0], c0 + 1 + T_RCD);
        chk(done_cyc[1] == c0 + 2 + T_RCD, "R7 oldest hit first", done_cyc[1], c0 + 2 + T_RCD);
        chk(done_cyc[2] == c0 + 3 + T_RCD, "R7 oldest hit next", done_cyc[2], c0 + 3 + T_RCD);
        chk(last_act[1] == c0 + 4 + T_RCD, "R8 column before activate", last_act[1], c0 + 4 + T_RCD);
        chk(done_cyc[3] == c0 + 4 + 2 * T_RCD, "R2 second bank", done_cyc[3], c0 + 4 + 2 * T_RCD);
        chk(act_count - acts0 == 2, "R5 hits need no activate", act_count - acts0, 2);
        chk(done_kind[0] == 2, "R12 read kind", done_kind[0], 2);

        // S2: row miss, look-ahead activate, bypass of a tRC-held request.
        idle(20);
        push(0, 0, 9, 4, 4, c1);
        push(0, 0, 3, 5, 5, a);
        push(0, 2, 1, 6, 6, a);
        idle(7);
        push(0, 3, 4, 7, 7, a);
        drain();
        chk(done_cyc[6] == c1 + 3 + T_RCD, "R10 look-ahead activate", done_cyc[6], c1 + 3 + T_RCD);
        chk(last_act[2] == c1 + 3, "R10 activate while older wait", last_act[2], c1 + 3);
        chk(done_cyc[4] == c1 + 1 + T_RP + T_RCD, "R4 miss latency", done_cyc[4], c1 + 1 + T_RP + T_RCD);
        chk(last_act[0] == c1 + 1 + T_RP + T_RC, "R3 activate at tRC", last_act[0], c1 + 1 + T_RP + T_RC);
        chk(done_cyc[7] == c1 + 11 + T_RCD, "R6 other bank served", done_cyc[7], c1 + 11 + T_RCD);
        chk(done_cyc[7] < done_cyc[5], "R6 bypass of tRC-held request", done_cyc[7], done_cyc[5]);
        chk(done_cyc[5] == c1 + 1 + T_RP + T_RC + T_RCD, "R3 held request latency",
            done_cyc[5], c1 + 1 + T_RP + T_RC + T_RCD);

        // S3: same line write then read, on a hit and on a miss.
        idle(20);
        push(1, 1, 2, 9, 8, c2);
        push(0, 1, 2, 9, 9, a);
        drain();
        chk(done_cyc[8] == c2 + 1, "R5 hit latency", done_cyc[8], c2 + 1);
        chk(done_cyc[9] == c2 + 2, "R7 same line order", done_cyc[9], c2 + 2);
        chk(done_kind[8] == 3 && done_kind[9] == 2, "R12 write then read kinds", done_kind[8], 3);
        idle(20);
        push(1, 1, 6, 1, 10, c3);
        push(0, 1, 6, 1, 11, a);
        drain();
        chk(done_cyc[10] == c3 + 1 + T_RP + T_RCD, "R7 write first on miss", done_cyc[10], c3 + 1 + T_RP + T_RCD);
        chk(done_cyc[11] == done_cyc[10] + 1, "R7 read after write", done_cyc[11], done_cyc[10] + 1);

        // S4: fill the queue behind a bank busy with row misses.
        idle(20);
        push(0, 0, 20, 0, 10, c4);
        for (int k = 1; k < 6; k++) push(0, 0, 20 + k, k, 10 + k, a);
        chk(req_ready == 0, "R1 ready low when full", int'(req_ready), 0);
        chk(cyc == c4 + 6, "R1 six accepts in a row", cyc, c4 + 6);
        push(0, 2, 1, 0, 0, a);
        chk(a >= c4 + 1 + T_RP + T_RCD, "R1 accept waits for room", a, c4 + 1 + T_RP + T_RCD);
        drain();

        // Sweep: each bank, a row miss then a hit on the new row.
        for (int b = 0; b < 4; b++) begin
            idle(20);
            push(b[0], b, 50 + b, b, b, a);
            drain();
            chk(done_cyc[b] == a + 1 + T_RP + T_RCD, "R4 sweep miss", done_cyc[b] - a, 1 + T_RP + T_RCD);
            push(0, b, 50 + b, b + 1, b, a);
            drain();
            chk(done_cyc[b] == a + 1, "R5 sweep hit", done_cyc[b] - a, 1);
        end

        for (int t = 0; t < 16; t++) chk(!outst[t], "R9 tag left open", int'(outst[t]), 0);
        chk(completed == accepted, "R9 completions equal accepts", completed, accepted);
        idle(5);
        summary();
    end
endmodule